// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between a CPU bus with 16-bit addresses and the memories on a game cartridge. CPU writes into the lower half of the address space never reach ROM. They are decoded into four write-only control registers instead.

- An access key opens or closes the gate to external memory.
- A 7-bit ROM bank number drives the switchable ROM window.
- A select value steers the external memory window either to one of four RAM banks or to one of five clock-counter registers.
- A latch bit produces a one-cycle capture pulse for the clock counters.

CPU reads of the two ROM windows are turned into a flat ROM address. Accesses to A000h–BFFFh become a RAM address with chip select and write enable, or a one-hot select and write enable for the clock register file.

Every output is registered and changes one clock after the bus cycle that causes it. The ROM array, the RAM array and the clock counters are outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset every control register is zero. The gate is closed, the ROM bank register holds 0 (which maps as bank 1), the external select holds 0 and the latch bit is 0. `rom_cs`, `ram_cs`, `ram_we`, `rtc_sel`, `rtc_we` and `latch_pulse` are low, and `ext_rdata` reads FFh.
- R2: A read at 0000h–3FFFh produces, one clock later, `rom_cs`=1 and `rom_addr` = {7'h00, addr[13:0]}, whatever the bank register holds. A write anywhere in 0000h–7FFFh never asserts `rom_cs`.
- R3: A write at 2000h–3FFFh stores data[6:0] as the ROM bank, and data bit 7 is ignored. A read at 4000h–7FFFh produces `rom_addr` = {bank, addr[13:0]}, where a stored bank of 00h is used as 01h.
- R4: A write of 0Ah at 0000h–1FFFh opens the gate. A write of any other value there closes it.
- R5: While the gate is closed, an access at A000h–BFFFh asserts none of `ram_cs`, `ram_we`, `rtc_sel` or `rtc_we`, and `ext_rdata` is FFh.
- R6: A write at 4000h–5FFFh stores data[3:0] as the external select, and data bits 7:4 are ignored. With the gate open and a select of 0–3, an access at A000h–BFFFh asserts `ram_cs` with `ram_addr` = {select[1:0], addr[12:0]}. A write also asserts `ram_we` with `ext_wdata` = data, and a read returns `ram_rdata` on `ext_rdata`.
- R7: With the gate open and a select of 8h–Ch, an access at A000h–BFFFh sets the one-hot `rtc_sel` bit (select−8). Bit 0 is seconds, then minutes, hours, days low and days high. A write also asserts `rtc_we`, and a read returns `rtc_rdata`.
- R8: With the gate open and a select of 4h–7h or Dh–Fh, an access at A000h–BFFFh asserts no strobe, and `ext_rdata` is FFh.
- R9: A write at 6000h–7FFFh stores data[0] as the latch bit. `latch_pulse` is high for exactly the one clock after a write that changes the stored bit from 0 to 1, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ext_rdata | output | 8 | Read data for the external window (FFh when nothing is selected) |
| rom_addr | output | 21 | Flat ROM address {bank, offset} |
| rom_cs | output | 1 | ROM chip select (reads only) |
| ram_addr | output | 15 | Flat RAM address {bank, offset} |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ext_wdata | output | 8 | Write data for RAM and clock registers |
| ram_rdata | input | 8 | Data returned by RAM for `ram_addr` |
| rtc_sel | output | 5 | One-hot clock register select |
| rtc_we | output | 1 | Clock register write enable |
| rtc_rdata | input | 8 | Data returned by the selected clock register |
| latch_pulse | output | 1 | One-cycle clock-counter capture pulse |

## Verification
ROM mapping is driven from a vector table. It pairs bank values with read addresses, so that a zero bank, a value with bit 7 set, the top bank and fixed-window reads each show whether the translation and the masking are applied, and in which window. The external window is exercised by distinct data written into each RAM bank and each clock register and then read back. This separates a wrong bank or select decode from a plain strobe error, and shows that no register aliases another. Selects in both unused gaps, several closing key values and a reopened gate show that gating and decode gaps suppress every strobe. Latch writes of 1 after 0, 1 after 1, 0, and a value with other bits set show that the pulse follows only a 0-to-1 change of bit 0.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Control-register targets, picked by address bits [15:13] of a write.
  typedef enum logic [2:0] {
    CT_GATE,
    CT_ROMB,
    CT_EXTSEL,
    CT_LATCH,
    CT_NONE
  } ctl_e;

  localparam logic [7:0] GATE_KEY     = 8'h0A;
  localparam int         CLK_SEL_BASE = 8;
  localparam logic [2:0] EXT_WIN_TOP  = 3'b101;

  function automatic ctl_e ctl_decode(input logic [2:0] top);
    case (top)
      3'b000:  return CT_GATE;
      3'b001:  return CT_ROMB;
      3'b010:  return CT_EXTSEL;
      3'b011:  return CT_LATCH;
      default: return CT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  gate_open,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [SEL_W-1:0]      ext_sel,
  output logic                  latch_we
);

  ctl_e tgt;
  assign tgt      = ctl_decode(addr[ADDR_W-1 -: 3]);
  assign latch_we = wr && (tgt == CT_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_open <= 1'b0;
      rom_bank  <= '0;
      ext_sel   <= '0;
    end else if (wr) begin
      case (tgt)
        CT_GATE:   gate_open <= (wdata == DATA_W'(GATE_KEY));
        CT_ROMB:   rom_bank  <= wdata[ROM_BANK_W-1:0];
        CT_EXTSEL: ext_sel   <= wdata[SEL_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map #(
  parameter int ADDR_W     = 16,
  parameter int ROM_BANK_W = 7,
  localparam int OFS_W     = ADDR_W - 2,
  localparam int ROM_AW    = ROM_BANK_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_cs
);

  logic [ROM_BANK_W-1:0] eff_bank;
  logic [ROM_BANK_W-1:0] win_bank;

  // A stored zero is used as bank 1 so that the switchable window
  // never shadows the fixed one.
  assign eff_bank = (rom_bank == '0) ? ROM_BANK_W'(1) : rom_bank;
  assign win_bank = addr[ADDR_W-2] ? eff_bank : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs   <= 1'b0;
      rom_addr <= '0;
    end else begin
      rom_cs   <= rd && !addr[ADDR_W-1];
      rom_addr <= {win_bank, addr[OFS_W-1:0]};
    end
  end

endmodule

// File: rtl/cbc_ext_map.sv
module cbc_ext_map
  import cbc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int RAM_BANK_W   = 2,
  parameter int SEL_W        = 4,
  parameter int NUM_CLK_REGS = 5,
  localparam int OFS_W       = ADDR_W - 3,
  localparam int RAM_AW      = RAM_BANK_W + OFS_W,
  localparam int NUM_RAM_BK  = 1 << RAM_BANK_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    gate_open,
  input  logic [SEL_W-1:0]        ext_sel,
  input  logic [DATA_W-1:0]       ram_rdata,
  input  logic [DATA_W-1:0]       rtc_rdata,
  output logic [RAM_AW-1:0]       ram_addr,
  output logic                    ram_cs,
  output logic                    ram_we,
  output logic [DATA_W-1:0]       ext_wdata,
  output logic [NUM_CLK_REGS-1:0] rtc_sel,
  output logic                    rtc_we,
  output logic [DATA_W-1:0]       ext_rdata
);

  logic [NUM_CLK_REGS-1:0] clk_hit;
  logic                    ram_hit;
  logic                    access;

  for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk_dec
    assign clk_hit[i] = (ext_sel == SEL_W'(CLK_SEL_BASE + i));
  end

  assign ram_hit = (ext_sel < SEL_W'(NUM_RAM_BK));
  assign access  = (rd || wr) && gate_open && (addr[ADDR_W-1 -: 3] == EXT_WIN_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ext_wdata <= '0;
      rtc_sel   <= '0;
      rtc_we    <= 1'b0;
    end else begin
      ram_cs    <= access && ram_hit;
      ram_we    <= access && ram_hit && wr;
      ram_addr  <= {ext_sel[RAM_BANK_W-1:0], addr[OFS_W-1:0]};
      ext_wdata <= wdata;
      rtc_sel   <= access ? clk_hit : '0;
      rtc_we    <= access && wr && (|clk_hit);
    end
  end

  always_comb begin
    if (ram_cs)        ext_rdata = ram_rdata;
    else if (|rtc_sel) ext_rdata = rtc_rdata;
    else               ext_rdata = '1;
  end

endmodule

// File: rtl/cbc_latch_edge.sv
module cbc_latch_edge (
  input  logic clk,
  input  logic rst,
  input  logic latch_we,
  input  logic latch_bit,
  output logic latch_pulse
);

  logic latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q     <= 1'b0;
      latch_pulse <= 1'b0;
    end else begin
      latch_pulse <= 1'b0;
      if (latch_we) begin
        latch_q     <= latch_bit;
        latch_pulse <= latch_bit && !latch_q;
      end
    end
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int ROM_BANK_W   = 7,
  parameter int RAM_BANK_W   = 2,
  parameter int SEL_W        = 4,
  parameter int NUM_CLK_REGS = 5,
  localparam int ROM_AW      = ROM_BANK_W + ADDR_W - 2,
  localparam int RAM_AW      = RAM_BANK_W + ADDR_W - 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       ext_rdata,
  output logic [ROM_AW-1:0]       rom_addr,
  output logic                    rom_cs,
  output logic [RAM_AW-1:0]       ram_addr,
  output logic                    ram_cs,
  output logic                    ram_we,
  output logic [DATA_W-1:0]       ext_wdata,
  input  logic [DATA_W-1:0]       ram_rdata,
  output logic [NUM_CLK_REGS-1:0] rtc_sel,
  output logic                    rtc_we,
  input  logic [DATA_W-1:0]       rtc_rdata,
  output logic                    latch_pulse
);

  logic                  gate_open;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [SEL_W-1:0]      ext_sel;
  logic                  latch_we;

  cbc_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .SEL_W(SEL_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .gate_open(gate_open), .rom_bank(rom_bank), .ext_sel(ext_sel),
    .latch_we(latch_we)
  );

  cbc_rom_map #(
    .ADDR_W(ADDR_W), .ROM_BANK_W(ROM_BANK_W)
  ) rom_i (
    .clk(clk), .rst(rst), .rd(cpu_rd), .addr(cpu_addr), .rom_bank(rom_bank),
    .rom_addr(rom_addr), .rom_cs(rom_cs)
  );

  cbc_ext_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BANK_W(RAM_BANK_W),
    .SEL_W(SEL_W), .NUM_CLK_REGS(NUM_CLK_REGS)
  ) ext_i (
    .clk(clk), .rst(rst), .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_wdata), .gate_open(gate_open), .ext_sel(ext_sel),
    .ram_rdata(ram_rdata), .rtc_rdata(rtc_rdata), .ram_addr(ram_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .ext_wdata(ext_wdata),
    .rtc_sel(rtc_sel), .rtc_we(rtc_we), .ext_rdata(ext_rdata)
  );

  cbc_latch_edge latch_i (
    .clk(clk), .rst(rst), .latch_we(latch_we), .latch_bit(cpu_wdata[0]),
    .latch_pulse(latch_pulse)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ADDR_W       = 16,
  parameter int ROM_BANK_W   = 7,
  parameter int NUM_CLK_REGS = 5,
  localparam int ROM_AW      = ROM_BANK_W + ADDR_W - 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpu_rd,
  input logic                    cpu_wr,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic                    wdata_b0,
  input logic [ROM_AW-1:0]       rom_addr,
  input logic                    rom_cs,
  input logic                    ram_cs,
  input logic                    ram_we,
  input logic [NUM_CLK_REGS-1:0] rtc_sel,
  input logic                    rtc_we,
  input logic                    latch_pulse
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rom_cs && !ram_cs && !ram_we && rtc_sel == '0 && !rtc_we && !latch_pulse)); // R1

  AST_ROM_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> $past(cpu_rd && !cpu_addr[ADDR_W-1])); // R2

  AST_ROM_BANK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && $past(cpu_addr[ADDR_W-2])) |-> (rom_addr[ROM_AW-1 -: ROM_BANK_W] != '0)); // R3

  AST_RAM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> $past(cpu_addr[ADDR_W-1 -: 3] == 3'b101)); // R6

  AST_RAM_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_cs && $past(cpu_wr))); // R6

  AST_RTC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rtc_sel)); // R7

  AST_RTC_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    rtc_we |-> (rtc_sel != '0)); // R7

  AST_TARGET_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_cs && rtc_sel != '0)); // R8

  AST_LATCH_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |-> $past(cpu_wr && wdata_b0 && cpu_addr[ADDR_W-1 -: 3] == 3'b011)); // R9

  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |=> !latch_pulse); // R9

endmodule

bind cart_bank_ctrl cbc_checker #(
  .ADDR_W(ADDR_W), .ROM_BANK_W(ROM_BANK_W), .NUM_CLK_REGS(NUM_CLK_REGS)
) chk_i (
  .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .wdata_b0(cpu_wdata[0]), .rom_addr(rom_addr), .rom_cs(rom_cs),
  .ram_cs(ram_cs), .ram_we(ram_we), .rtc_sel(rtc_sel), .rtc_we(rtc_we),
  .latch_pulse(latch_pulse)
);

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  ext_rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [14:0] ram_addr;
  logic        ram_cs;
  logic        ram_we;
  logic [7:0]  ext_wdata;
  logic [7:0]  ram_rdata;
  logic [4:0]  rtc_sel;
  logic        rtc_we;
  logic [7:0]  rtc_rdata;
  logic        latch_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ext_rdata(ext_rdata), .rom_addr(rom_addr),
    .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ext_wdata(ext_wdata), .ram_rdata(ram_rdata), .rtc_sel(rtc_sel),
    .rtc_we(rtc_we), .rtc_rdata(rtc_rdata), .latch_pulse(latch_pulse)
  );

  // Small memory models: RAM indexed by {bank, offset[3:0]}, five clock regs.
  logic [7:0] ram_m [64];
  logic [7:0] rtc_m [5];

  assign ram_rdata = ram_m[{ram_addr[14:13], ram_addr[3:0]}];

  always_comb begin
    rtc_rdata = 8'hFF;
    for (int i = 0; i < 5; i++) if (rtc_sel[i]) rtc_rdata = rtc_m[i];
  end

  always @(posedge clk) begin
    if (ram_we) ram_m[{ram_addr[14:13], ram_addr[3:0]}] <= ext_wdata;
    if (rtc_we) for (int i = 0; i < 5; i++) if (rtc_sel[i]) rtc_m[i] <= ext_wdata;
  end

  // ROM vectors: {bank written, read address, expected rom_addr}
  localparam logic [44:0] ROM_VEC [8] = '{
    {8'h00, 16'h4123, 7'h01, 14'h0123},
    {8'h05, 16'h7FFF, 7'h05, 14'h3FFF},
    {8'h7F, 16'h4000, 7'h7F, 14'h0000},
    {8'h85, 16'h5555, 7'h05, 14'h1555},
    {8'h80, 16'h4001, 7'h01, 14'h0001},
    {8'h33, 16'h1234, 7'h00, 14'h1234},
    {8'h33, 16'h3FFF, 7'h00, 14'h3FFF},
    {8'h01, 16'h6ABC, 7'h01, 14'h2ABC}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample just after the next posedge.
  task automatic bus(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic wr8(input logic [15:0] a, input logic [7:0] d);
    bus(1'b0, 1'b1, a, d);
  endtask

  task automatic rd8(input logic [15:0] a);
    bus(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state of every output
    check("R1 rom_cs", 32'(rom_cs), 32'd0);
    check("R1 ram_cs", 32'(ram_cs), 32'd0);
    check("R1 rtc_sel", 32'(rtc_sel), 32'd0);
    check("R1 latch_pulse", 32'(latch_pulse), 32'd0);
    check("R1 ext_rdata", 32'(ext_rdata), 32'hFF);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset bank register maps as bank 1
    rd8(16'h4000);
    check("R1 reset bank", 32'(rom_addr), 32'({7'h01, 14'h0000}));

    // R5: gate closed after reset
    rd8(16'hA000);
    check("R5 closed rd data", 32'(ext_rdata), 32'hFF);
    check("R5 closed ram_cs", 32'(ram_cs), 32'd0);
    wr8(16'hA000, 8'h55);
    check("R5 closed ram_we", 32'(ram_we), 32'd0);
    wr8(16'h4000, 8'h08);
    wr8(16'hB000, 8'h55);
    check("R5 closed rtc_we", 32'({rtc_we, rtc_sel}), 32'd0);

    // R2/R3: table of ROM mappings
    for (int k = 0; k < 8; k++) begin
      wr8(16'h3000, ROM_VEC[k][44:37]);
      check("R2 write no rom_cs", 32'(rom_cs), 32'd0);
      rd8(ROM_VEC[k][36:21]);
      check("R2 rom_cs", 32'(rom_cs), 32'd1);
      check("R3 rom_addr", 32'(rom_addr), 32'(ROM_VEC[k][20:0]));
    end

    // R4: open gate
    wr8(16'h0000, 8'h0A);

    // R6: write distinct data into each RAM bank
    for (int b = 0; b < 4; b++) begin
      wr8(16'h4000, 8'(b));
      wr8(16'hA003, 8'(8'h10 + b));
      check("R6 ram_we", 32'({ram_cs, ram_we}), 32'd3);
      check("R6 ram_addr wr", 32'(ram_addr), 32'({2'(b), 13'h0003}));
      check("R6 wdata", 32'(ext_wdata), 32'(8'h10 + b));
    end
    for (int b = 0; b < 4; b++) begin
      wr8(16'h4000, 8'(8'hF0 | b));
      rd8(16'hB003);
      check("R6 ram_addr rd", 32'(ram_addr), 32'({2'(b), 13'h1003}));
      check("R6 read data", 32'(ext_rdata), 32'(8'h10 + b));
      check("R6 no rtc", 32'(rtc_sel), 32'd0);
    end

    // R7: each clock register
    for (int i = 0; i < 5; i++) begin
      wr8(16'h5FFF, 8'(8 + i));
      wr8(16'hA100, 8'(8'h20 + i));
      check("R7 rtc_sel wr", 32'(rtc_sel), 32'(5'b1 << i));
      check("R7 rtc_we", 32'({rtc_we, ram_cs}), 32'h2);
    end
    for (int i = 0; i < 5; i++) begin
      wr8(16'h4000, 8'(8 + i));
      rd8(16'hBFFF);
      check("R7 rtc_sel rd", 32'(rtc_sel), 32'(5'b1 << i));
      check("R7 read data", 32'(ext_rdata), 32'(8'h20 + i));
    end

    // R8: unused selects
    for (int s = 0; s < 4; s++) begin
      logic [7:0] sv;
      sv = (s == 0) ? 8'h04 : (s == 1) ? 8'h07 : (s == 2) ? 8'h0D : 8'h0F;
      wr8(16'h4000, sv);
      rd8(16'hA003);
      check("R8 gap read", 32'(ext_rdata), 32'hFF);
      wr8(16'hA003, 8'h99);
      check("R8 gap strobes", 32'({ram_cs, ram_we, rtc_sel, rtc_we}), 32'd0);
    end
    wr8(16'h4000, 8'h00);
    rd8(16'hA003);
    check("R8 bank0 intact", 32'(ext_rdata), 32'h10);

    // R4: other key values close the gate, 0Ah reopens it
    wr8(16'h1FFF, 8'h0B);
    rd8(16'hA003);
    check("R4 closed by 0B", 32'(ext_rdata), 32'hFF);
    wr8(16'h1000, 8'h0A);
    rd8(16'hA003);
    check("R4 reopened", 32'(ext_rdata), 32'h10);
    wr8(16'h0000, 8'h8A);
    wr8(16'hA003, 8'h77);
    check("R4 closed by 8A", 32'({ram_cs, ram_we}), 32'd0);
    wr8(16'h0000, 8'h0A);
    rd8(16'hA003);
    check("R4 write ignored", 32'(ext_rdata), 32'h10);

    // R9: latch edge
    wr8(16'h6000, 8'h01);
    check("R9 pulse 0->1", 32'(latch_pulse), 32'd1);
    rd8(16'h0000);
    check("R9 pulse one cycle", 32'(latch_pulse), 32'd0);
    wr8(16'h7FFF, 8'h01);
    check("R9 no pulse 1->1", 32'(latch_pulse), 32'd0);
    wr8(16'h6000, 8'h00);
    check("R9 no pulse 1->0", 32'(latch_pulse), 32'd0);
    wr8(16'h6123, 8'h03);
    check("R9 pulse again", 32'(latch_pulse), 32'd1);
    wr8(16'h6000, 8'h00);
    wr8(16'h6000, 8'hFE);
    check("R9 bit0 only", 32'(latch_pulse), 32'd0);

    finish_run();
  end

endmodule